// File: doc/BRIEF.md
# Dual-Pointer Video Memory Access Port

This block is the byte-wide host register front end of a video controller. A CPU reaches a 128 KB video memory through it. It keeps two independent 17-bit address pointers. A select bit in a control register decides which pointer appears at the three shared address registers (low, middle and high byte).

Two data ports read or write the video memory, each at its own pointer. After every data port access, only the pointer of that port moves. It steps up or down by a stride chosen from a 16-entry table. The table mixes powers of two with multiples of 40, so software can walk along a row or jump down rows of a frame buffer.

The video memory sits outside the block behind a simple synchronous interface: one access per cycle, with read data returned one cycle after the read strobe.

Top module: `vpf_top`

## Requirements
- R1: After reset, every register offset (0 to 7) reads back 0x00. Both pointers, their decrement flags, their stride codes and the select bit are zero.
- R2: Offsets 0, 1 and 2 read and write bits 7:0, 15:8 and the high byte of the pointer chosen by bit 0 of the control register at offset 5. A write through this window leaves the other pointer unchanged.
- R3: The high address byte holds pointer bit 16 in bit 0, reads 0 in bits 2:1, holds the decrement flag in bit 3 and holds the 4-bit stride code in bits 7:4. Each pointer keeps its own flag and code, and reads them back there.
- R4: Stride codes 0 to 10 step the pointer by 0, 1, 2, 4, 8, 16, 32, 64, 128, 256 and 512. Code 0 leaves the pointer in place.
- R5: Stride codes 11 to 15 step the pointer by 40, 80, 160, 320 and 640.
- R6: When the decrement flag is set, the pointer steps down by the same stride instead of up.
- R7: Data port 0 (offset 3) always accesses memory at pointer 0, and data port 1 (offset 4) always at pointer 1, whatever the select bit holds.
- R8: A data port write stores the byte at the port's current pointer. Only that port's pointer then advances, by its own stride.
- R9: A data port read returns the byte at the port's current pointer, and then only that pointer advances. Every read (register or data port) presents its byte on bus_rdata with bus_rvalid high in the cycle after the strobe.
- R10: Pointer steps wrap modulo 2^17 in both directions.
- R11: A write through one data port, followed in the very next cycle by a read of the same address through the other port, returns the new byte.
- R12: Offsets 6 and 7 read 0x00, and writes to them change no register. Bits 7:1 of the control register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| bus_addr | input | 3 | Register offset of the host access |
| bus_wr | input | 1 | Host write strobe, one cycle per access; wins over bus_rd |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High in the cycle after a read strobe |
| mem_addr | output | 17 | Video memory address |
| mem_we | output | 1 | Video memory write enable |
| mem_re | output | 1 | Video memory read enable; data is expected one cycle later |
| mem_wdata | output | 8 | Video memory write byte |
| mem_rdata | input | 8 | Video memory read byte, one cycle after mem_re |

## Verification
Two situations are hard to reach from the ports. The first is a step across the top or bottom of the 17-bit space. The bench reaches it by loading a pointer next to the boundary and making one data port access with a stride that crosses it. The second is a same-address handoff between the two ports in back-to-back cycles. Here both pointers are aimed at one address with a zero stride, and a write on one port is followed immediately by a read on the other. The bench also shows that the select bit does not steer the data ports: it leaves the window on pointer 1 while it writes through port 0, then reads the bytes back through port 1.

// File: rtl/vpf_pkg.sv
package vpf_pkg;
  localparam int ADDR_W  = 17;
  localparam int BYTE_W  = 8;
  localparam int NUM_PTR = 2;
  localparam int CODE_W  = 4;
  localparam int OFS_W   = 3;

  localparam logic [OFS_W-1:0] OFS_LO    = 3'd0;
  localparam logic [OFS_W-1:0] OFS_MID   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_HI    = 3'd2;
  localparam logic [OFS_W-1:0] OFS_DATA0 = 3'd3;
  localparam logic [OFS_W-1:0] OFS_DATA1 = 3'd4;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd5;

  typedef logic [ADDR_W-1:0] vaddr_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/vpf_rst_sync.sv
module vpf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/vpf_stride_lut.sv
module vpf_stride_lut
  import vpf_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output vaddr_t            stride
);
  localparam logic [CODE_W-1:0] ROW_BASE_CODE = 4'd11;
  localparam vaddr_t            ROW_UNIT      = vaddr_t'(40);
  localparam vaddr_t            UNIT          = vaddr_t'(1);

  // codes 1..10: powers of two; 11..15: 40 doubled each step
  always_comb begin
    stride = '0;
    if (code >= ROW_BASE_CODE)
      stride = ROW_UNIT << (code - ROW_BASE_CODE);
    else if (code != '0)
      stride = UNIT << (code - 4'd1);
  end
endmodule

// File: rtl/vpf_pointer.sv
module vpf_pointer
  import vpf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_mid,
  input  logic              wr_hi,
  input  byte_t             byte_in,
  input  logic              top_bit_in,
  input  logic              decr_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic              step,
  output vaddr_t            addr_o,
  output byte_t             lo_o,
  output byte_t             mid_o,
  output byte_t             hi_o
);
  vaddr_t            addr_q, addr_d;
  logic              decr_q, decr_d;
  logic [CODE_W-1:0] code_q, code_d;
  vaddr_t            stride;
  logic              addr_en, cfg_en;

  vpf_stride_lut u_lut (
    .code   (code_q),
    .stride (stride)
  );

  assign addr_en = wr_lo | wr_mid | wr_hi | step;
  assign cfg_en  = wr_hi;

  always_comb begin
    addr_d = addr_q;
    if (wr_lo)       addr_d[7:0]        = byte_in;
    else if (wr_mid) addr_d[15:8]       = byte_in;
    else if (wr_hi)  addr_d[ADDR_W-1]   = top_bit_in;
    else if (step) begin
      if (decr_q) addr_d = addr_q - stride;
      else        addr_d = addr_q + stride;
    end
  end

  always_comb begin
    decr_d = decr_in;
    code_d = code_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decr_q <= 1'b0;
      code_q <= '0;
    end else if (cfg_en) begin
      decr_q <= decr_d;
      code_q <= code_d;
    end
  end

  assign addr_o = addr_q;
  assign lo_o   = addr_q[7:0];
  assign mid_o  = addr_q[15:8];
  assign hi_o   = {code_q, decr_q, 2'b00, addr_q[ADDR_W-1]};

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_mid || wr_hi || step) |=> $stable(addr_q) && $stable(code_q) && $stable(decr_q)); // R8

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !decr_q) |=> vaddr_t'(addr_q - $past(addr_q)) == $past(stride)); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && decr_q) |=> vaddr_t'($past(addr_q) - addr_q) == $past(stride)); // R6

  AST_POW2_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q inside {[4'd1:4'd10]}) |-> $countones(stride) == 1); // R4

  AST_ROW_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q >= 4'd11) |-> (stride % 40 == 0) && (stride >= 40) && (stride <= 640)); // R5
endmodule

// File: rtl/vpf_top.sv
module vpf_top
  import vpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        bus_rvalid,
  output logic [16:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  logic   rst_sync_n;
  logic   rd_fire, wr_fire, dport_hit, dport1_hit;
  logic   sel_q, sel_d, sel_en;
  logic   rvalid_q, from_mem_q, from_mem_d;
  byte_t  rdata_q, rdata_d;

  vaddr_t ptr_addr [NUM_PTR];
  byte_t  ptr_lo   [NUM_PTR];
  byte_t  ptr_mid  [NUM_PTR];
  byte_t  ptr_hi   [NUM_PTR];

  vpf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign wr_fire    = bus_wr;
  assign rd_fire    = bus_rd & ~bus_wr;
  assign dport1_hit = (bus_addr == OFS_DATA1);
  assign dport_hit  = (bus_addr == OFS_DATA0) | dport1_hit;

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    logic win_sel;
    assign win_sel = (sel_q == 1'(g));

    vpf_pointer u_ptr (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_lo      (wr_fire & win_sel & (bus_addr == OFS_LO)),
      .wr_mid     (wr_fire & win_sel & (bus_addr == OFS_MID)),
      .wr_hi      (wr_fire & win_sel & (bus_addr == OFS_HI)),
      .byte_in    (bus_wdata),
      .top_bit_in (bus_wdata[0]),
      .decr_in    (bus_wdata[3]),
      .code_in    (bus_wdata[7:4]),
      .step       ((wr_fire | rd_fire) & (bus_addr == (OFS_DATA0 + 3'(g)))),
      .addr_o     (ptr_addr[g]),
      .lo_o       (ptr_lo[g]),
      .mid_o      (ptr_mid[g]),
      .hi_o       (ptr_hi[g])
    );
  end

  // memory side: one access per cycle, at the pointer owned by the port
  assign mem_addr  = dport1_hit ? ptr_addr[1] : ptr_addr[0];
  assign mem_we    = wr_fire & dport_hit;
  assign mem_re    = rd_fire & dport_hit;
  assign mem_wdata = bus_wdata;

  // control register
  assign sel_en = wr_fire & (bus_addr == OFS_CTRL);
  assign sel_d  = bus_wdata[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sel_q <= 1'b0;
    else if (sel_en)  sel_q <= sel_d;
  end

  // register readback
  always_comb begin
    rdata_d    = '0;
    from_mem_d = 1'b0;
    case (bus_addr)
      OFS_LO:    rdata_d = ptr_lo[sel_q];
      OFS_MID:   rdata_d = ptr_mid[sel_q];
      OFS_HI:    rdata_d = ptr_hi[sel_q];
      OFS_DATA0,
      OFS_DATA1: from_mem_d = 1'b1;
      OFS_CTRL:  rdata_d = {7'b0, sel_q};
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rvalid_q   <= 1'b0;
      from_mem_q <= 1'b0;
    end else begin
      rvalid_q   <= rd_fire;
      from_mem_q <= rd_fire & from_mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rdata_q <= '0;
    else if (rd_fire) rdata_q <= rdata_d;
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = from_mem_q ? mem_rdata : rdata_q;

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_we && mem_re)); // R8

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_rd && !bus_wr) |=> bus_rvalid); // R9

  AST_PORT0_KEEPS_PTR1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_wr || bus_rd) && bus_addr == OFS_DATA0) |=> $stable(ptr_addr[1])); // R7

  AST_PORT1_KEEPS_PTR0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((bus_wr || bus_rd) && bus_addr == OFS_DATA1) |=> $stable(ptr_addr[0])); // R7

  AST_SPARE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr > OFS_CTRL) |=> $stable(sel_q) && $stable(ptr_addr[0]) && $stable(ptr_addr[1])); // R12
endmodule

// File: tb/test_vpf_top.sv
module test_vpf_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid;
  logic [16:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vpf_top i_vpf_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] fill_of(logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
  endfunction

  // environment memory
  logic [7:0] env_mem [logic [16:0]];
  always @(posedge clk) begin
    if (mem_we) env_mem[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= env_mem.exists(mem_addr) ? env_mem[mem_addr] : fill_of(mem_addr);
  end

  // reference model
  logic [7:0]  ref_mem [logic [16:0]];
  logic [16:0] m_ptr  [2];
  logic        m_decr [2];
  logic [3:0]  m_code [2];
  logic        m_sel;

  function automatic int stride_of(logic [3:0] c);
    case (c)
      4'd0: return 0;    4'd1: return 1;    4'd2: return 2;    4'd3: return 4;
      4'd4: return 8;    4'd5: return 16;   4'd6: return 32;   4'd7: return 64;
      4'd8: return 128;  4'd9: return 256;  4'd10: return 512; 4'd11: return 40;
      4'd12: return 80;  4'd13: return 160; 4'd14: return 320; default: return 640;
    endcase
  endfunction

  function automatic void advance(int p);
    if (m_decr[p]) m_ptr[p] = m_ptr[p] - 17'(stride_of(m_code[p]));
    else           m_ptr[p] = m_ptr[p] + 17'(stride_of(m_code[p]));
  endfunction

  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic idle_bus();
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic bus_write(input logic [2:0] off, input logic [7:0] d);
    int p;
    @(negedge clk);
    bus_addr = off; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    case (off)
      3'd0: m_ptr[m_sel][7:0]  = d;
      3'd1: m_ptr[m_sel][15:8] = d;
      3'd2: begin m_ptr[m_sel][16] = d[0]; m_decr[m_sel] = d[3]; m_code[m_sel] = d[7:4]; end
      3'd3, 3'd4: begin p = (off == 3'd4) ? 1 : 0; ref_mem[m_ptr[p]] = d; advance(p); end
      3'd5: m_sel = d[0];
      default: ;
    endcase
    @(posedge clk); #1;
    idle_bus();
  endtask

  task automatic bus_read(input logic [2:0] off, input string tag);
    logic [7:0] e;
    int p;
    @(negedge clk);
    bus_addr = off; bus_rd = 1; bus_wr = 0;
    case (off)
      3'd0: e = m_ptr[m_sel][7:0];
      3'd1: e = m_ptr[m_sel][15:8];
      3'd2: e = {m_code[m_sel], m_decr[m_sel], 2'b00, m_ptr[m_sel][16]};
      3'd3, 3'd4: begin
        p = (off == 3'd4) ? 1 : 0;
        e = ref_mem.exists(m_ptr[p]) ? ref_mem[m_ptr[p]] : fill_of(m_ptr[p]);
        advance(p);
      end
      3'd5: e = {7'b0, m_sel};
      default: e = 8'h00;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    idle_bus();
  endtask

  task automatic set_ptr(input bit p, input logic [16:0] a, input logic [3:0] c, input bit dn);
    bus_write(3'd5, {7'b0, p});
    bus_write(3'd0, a[7:0]);
    bus_write(3'd1, a[15:8]);
    bus_write(3'd2, {c, dn, 2'b00, a[16]});
  endtask

  task automatic read_window(input bit p, input string tag);
    bus_write(3'd5, {7'b0, p});
    bus_read(3'd0, tag);
    bus_read(3'd1, tag);
    bus_read(3'd2, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9: unexpected read data got %02h expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s: got %02h expected %02h", t, bus_rdata, e);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_bus();
    rst_n = 0;
    for (int i = 0; i < 2; i++) begin m_ptr[i] = 0; m_decr[i] = 0; m_code[i] = 0; end
    m_sel = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state, R12 spare offsets
    for (int o = 0; o < 8; o++) bus_read(3'(o), (o > 5) ? "R12" : "R1");

    // R2 window follows select bit
    set_ptr(1'b0, 17'h13412, 4'd0, 1'b0);
    set_ptr(1'b1, 17'h0CDAB, 4'd0, 1'b0);
    read_window(1'b1, "R2");
    read_window(1'b0, "R2");

    // R3 high byte layout: unused bits 2:1 dropped
    bus_write(3'd5, 8'h00);
    bus_write(3'd2, 8'hF7);
    bus_read(3'd2, "R3");
    bus_write(3'd5, 8'h01);
    bus_read(3'd2, "R3");

    // R12 spare writes, control upper bits
    bus_write(3'd5, 8'hFE);
    bus_read(3'd5, "R12");
    bus_write(3'd6, 8'hFF);
    bus_write(3'd7, 8'h81);
    bus_read(3'd6, "R12");
    bus_read(3'd7, "R12");
    read_window(1'b0, "R12");

    // R4 / R5 stride table, R9 read before advance
    for (int c = 0; c < 16; c++) begin
      set_ptr(1'b0, 17'h01000, 4'(c), 1'b0);
      bus_read(3'd3, "R9");
      read_window(1'b0, (c <= 10) ? "R4" : "R5");
    end

    // R6 decrement
    set_ptr(1'b0, 17'h01000, 4'd3, 1'b1);
    bus_read(3'd3, "R9");
    bus_read(3'd3, "R9");
    read_window(1'b0, "R6");
    set_ptr(1'b1, 17'h02000, 4'd13, 1'b1);
    bus_read(3'd4, "R9");
    read_window(1'b1, "R6");

    // R7 / R8 port ownership regardless of select
    set_ptr(1'b0, 17'h00200, 4'd1, 1'b0);
    set_ptr(1'b1, 17'h00300, 4'd2, 1'b0);
    bus_write(3'd3, 8'h5A);
    bus_write(3'd3, 8'h5B);
    bus_write(3'd4, 8'hC1);
    read_window(1'b0, "R8");
    read_window(1'b1, "R8");
    bus_write(3'd5, 8'h00);
    bus_read(3'd4, "R7");
    set_ptr(1'b1, 17'h00200, 4'd1, 1'b0);
    bus_write(3'd5, 8'h00);
    bus_read(3'd4, "R7");
    bus_read(3'd4, "R7");
    bus_write(3'd5, 8'h01);
    set_ptr(1'b0, 17'h00300, 4'd0, 1'b0);
    bus_write(3'd5, 8'h01);
    bus_read(3'd3, "R8");

    // R10 wrap both ways
    set_ptr(1'b0, 17'h1FFFF, 4'd1, 1'b0);
    bus_write(3'd3, 8'h77);
    read_window(1'b0, "R10");
    set_ptr(1'b0, 17'h1FFFF, 4'd0, 1'b0);
    bus_read(3'd3, "R10");
    set_ptr(1'b1, 17'h00000, 4'd15, 1'b1);
    bus_read(3'd4, "R10");
    read_window(1'b1, "R10");

    // R11 back-to-back cross-port handoff
    set_ptr(1'b0, 17'h00500, 4'd0, 1'b0);
    set_ptr(1'b1, 17'h00500, 4'd0, 1'b0);
    bus_write(3'd3, 8'h99);
    bus_read(3'd4, "R11");
    bus_write(3'd4, 8'h3C);
    bus_read(3'd3, "R11");

    repeat (6) @(posedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9: got %0d pending reads expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule